// File: doc/BRIEF.md
# Memory Operation Ordering Unit

This block holds the memory operations of a dynamically scheduled floating-point pipeline while they wait on data or on each other. Loads sit in a set of tagged buffers and behave like result producers. When a load finishes, its data and the buffer's own tag leave the block for the result bus, and the buffer becomes free again. Stores sit in a small in-order queue. Each store keeps its target address and either its value or the tag of the unit that will produce that value. While it waits, the store watches the result bus for that tag.

When a load is issued, its address is compared with the addresses of every store still waiting in the queue. A load whose address matches none of them goes to memory at once, ahead of those older stores. A load that matches one or more of them waits until each of them has written memory. A single memory port serves both kinds of operation with a fixed read latency. The port gives eligible loads priority over the head store, so a store issued after a load can never overwrite the value that load returns.

Top module: `mem_order_unit`

## Requirements
- R1: After reset, the issue port accepts both loads and stores, no load completion is signalled, and the first load issued gets tag 1.
- R2: Each load gets a tag in the range 1..NUM_LD (tag = buffer index + 1, the lowest free buffer first). No two outstanding loads share a tag, and every completion carries the tag of an outstanding load.
- R3: Up to NUM_LD (6) loads can be outstanding at once. While all load buffers are busy, iss_ready_o is low for a load.
- R4: The store queue holds NUM_ST (3) entries. While it is full, iss_ready_o is low for a store, and a load can still be accepted.
- R5: A store issued with iss_tag_i = 0 takes its value from iss_data_i. A store issued with a nonzero tag takes rb_data_i when the result bus shows that tag, including in the cycle of issue.
- R6: A store writes memory only once it holds its value, and stores write memory in issue order, even when their values arrive out of order.
- R7: A load whose address differs from every older waiting store goes to memory without waiting for those stores.
- R8: A load whose address matches an older waiting store completes only after that store has written memory, and it returns the value of the youngest older store to that address.
- R9: A load with no blocking store that is accepted at clock edge E0 shows ld_done_valid_o, its tag and its data after edge E0+MEM_LAT and not before. Every load eventually completes, and its buffer is then freed.
- R10: When a load and the head store are both ready in the same cycle, the load uses the memory port first. A store issued after a load never changes the value that load returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid_i | input | 1 | Issue request |
| iss_store_i | input | 1 | 1 = store, 0 = load |
| iss_addr_i | input | AW | Memory word address |
| iss_tag_i | input | TW | Store value producer tag, 0 = value present |
| iss_data_i | input | DW | Store value when iss_tag_i is 0 |
| iss_ready_o | output | 1 | A buffer of the requested kind is free |
| iss_ld_tag_o | output | TW | Tag a load issued now will receive |
| rb_valid_i | input | 1 | Result bus valid |
| rb_tag_i | input | TW | Result bus producer tag |
| rb_data_i | input | DW | Result bus data |
| ld_done_valid_o | output | 1 | A load completes this cycle |
| ld_done_tag_o | output | TW | Tag of the completing load |
| ld_done_data_o | output | DW | Data read by the completing load |

## Verification
The bench sweeps every pairing of a waiting store address with a later load address. A design that compares addresses wrongly would either stall loads it should let pass or let a load read memory before the store it depends on has written. Stores to the same word have their values delivered in reverse order. A design that drains stores as soon as their values arrive would leave the older value in memory. A load that sits between two stores to the same address is released in the same cycle that the newer store becomes ready. A design that lets stores win the port would return the newer value. Full load and store buffers are tested to confirm that each kind stalls on its own, and a long mixed sequence checks every returned value against a program-order model.

// File: rtl/mou_pkg.sv
package mou_pkg;
    typedef enum logic [1:0] {
        LB_FREE = 2'd0,
        LB_WAIT = 2'd1,
        LB_SENT = 2'd2
    } lb_state_e;
endpackage

// File: rtl/mou_store_queue.sv
module mou_store_queue #(
    parameter int NUM_ST = 3,
    parameter int AW     = 4,
    parameter int DW     = 16,
    parameter int TW     = 4,
    localparam int PW    = (NUM_ST > 1) ? $clog2(NUM_ST) : 1,
    localparam int CW    = $clog2(NUM_ST + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [AW-1:0]                push_addr_i,
    input  logic [TW-1:0]                push_tag_i,
    input  logic [DW-1:0]                push_val_i,
    input  logic                         rb_valid_i,
    input  logic [TW-1:0]                rb_tag_i,
    input  logic [DW-1:0]                rb_data_i,
    input  logic                         pop_i,
    output logic                         full_o,
    output logic                         head_ready_o,
    output logic [AW-1:0]                head_addr_o,
    output logic [DW-1:0]                head_data_o,
    output logic [PW-1:0]                head_idx_o,
    output logic [NUM_ST-1:0]            valid_o,
    output logic [NUM_ST-1:0][AW-1:0]    addr_o
);
    typedef struct packed {
        logic [NUM_ST-1:0]         vld;
        logic [NUM_ST-1:0][AW-1:0] addr;
        logic [NUM_ST-1:0][TW-1:0] tag;
        logic [NUM_ST-1:0][DW-1:0] val;
        logic [PW-1:0]             head;
        logic [PW-1:0]             tail;
        logic [CW-1:0]             cnt;
    } sq_t;

    sq_t sq_d, sq_q;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(NUM_ST - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        sq_d = sq_q;
        for (int s = 0; s < NUM_ST; s++) begin
            if (sq_q.vld[s] && sq_q.tag[s] != '0 && rb_valid_i && rb_tag_i == sq_q.tag[s]) begin
                sq_d.val[s] = rb_data_i;
                sq_d.tag[s] = '0;
            end
        end
        if (pop_i) begin
            sq_d.vld[sq_q.head] = 1'b0;
            sq_d.head           = wrap_inc(sq_q.head);
        end
        if (push_i) begin
            sq_d.vld[sq_q.tail]  = 1'b1;
            sq_d.addr[sq_q.tail] = push_addr_i;
            if (push_tag_i != '0 && rb_valid_i && rb_tag_i == push_tag_i) begin
                sq_d.tag[sq_q.tail] = '0;
                sq_d.val[sq_q.tail] = rb_data_i;
            end else begin
                sq_d.tag[sq_q.tail] = push_tag_i;
                sq_d.val[sq_q.tail] = push_val_i;
            end
            sq_d.tail = wrap_inc(sq_q.tail);
        end
        sq_d.cnt = sq_q.cnt + CW'(push_i) - CW'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign full_o       = (sq_q.cnt == CW'(NUM_ST));
    assign head_ready_o = sq_q.vld[sq_q.head] && (sq_q.tag[sq_q.head] == '0);
    assign head_addr_o  = sq_q.addr[sq_q.head];
    assign head_data_o  = sq_q.val[sq_q.head];
    assign head_idx_o   = sq_q.head;
    assign valid_o      = sq_q.vld;
    assign addr_o       = sq_q.addr;

    // R4: never push into a full queue, count stays bounded
    p_push_not_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.cnt <= CW'(NUM_ST));
    // R6: a store leaves only from the head once its value is held
    p_pop_has_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (sq_q.vld[sq_q.head] && sq_q.tag[sq_q.head] == '0));
endmodule

// File: rtl/mou_load_table.sv
module mou_load_table
    import mou_pkg::*;
#(
    parameter int NUM_LD = 6,
    parameter int NUM_ST = 3,
    parameter int AW     = 4,
    localparam int IW    = $clog2(NUM_LD)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_i,
    input  logic [AW-1:0]                alloc_addr_i,
    input  logic [NUM_ST-1:0]            alloc_dep_i,
    input  logic [NUM_ST-1:0]            st_done_i,
    input  logic [NUM_LD-1:0]            grant_i,
    input  logic                         ret_valid_i,
    input  logic [IW-1:0]                ret_idx_i,
    output logic                         free_any_o,
    output logic [IW-1:0]                free_idx_o,
    output logic [NUM_LD-1:0]            elig_o,
    output logic [NUM_LD-1:0][AW-1:0]    addr_o
);
    typedef struct packed {
        lb_state_e [NUM_LD-1:0]             st;
        logic [NUM_LD-1:0][AW-1:0]          addr;
        logic [NUM_LD-1:0][NUM_ST-1:0]      dep;
    } lt_t;

    lt_t lt_d, lt_q;

    always_comb begin
        free_any_o = 1'b0;
        free_idx_o = '0;
        for (int l = NUM_LD - 1; l >= 0; l--) begin
            if (lt_q.st[l] == LB_FREE) begin
                free_any_o = 1'b1;
                free_idx_o = IW'(l);
            end
        end
    end

    always_comb begin
        lt_d = lt_q;
        for (int l = 0; l < NUM_LD; l++) begin
            lt_d.dep[l] = lt_q.dep[l] & ~st_done_i;
            if (grant_i[l]) lt_d.st[l] = LB_SENT;
            if (ret_valid_i && ret_idx_i == IW'(l)) lt_d.st[l] = LB_FREE;
            if (alloc_i && free_idx_o == IW'(l)) begin
                lt_d.st[l]   = LB_WAIT;
                lt_d.addr[l] = alloc_addr_i;
                lt_d.dep[l]  = alloc_dep_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lt_q <= '0;
        else        lt_q <= lt_d;
    end

    for (genvar g = 0; g < NUM_LD; g++) begin : g_elig
        assign elig_o[g] = (lt_q.st[g] == LB_WAIT) && (lt_q.dep[g] == '0);
        assign addr_o[g] = lt_q.addr[g];
    end

    // R8: only a load with every blocking store drained may reach memory
    p_grant_eligible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_i) |-> ($onehot0(grant_i) && ((grant_i & ~elig_o) == '0)));
    // R9: a memory return always belongs to a load that was sent
    p_return_sent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_i |-> (lt_q.st[ret_idx_i] == LB_SENT));
    // R3: allocation only into a free buffer
    p_alloc_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> free_any_o);
endmodule

// File: rtl/mou_mem_model.sv
module mou_mem_model #(
    parameter int AW  = 4,
    parameter int DW  = 16,
    parameter int IW  = 3,
    parameter int LAT = 2,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic          req_write_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    input  logic [IW-1:0] req_idx_i,
    output logic          ret_valid_o,
    output logic [IW-1:0] ret_idx_o,
    output logic [DW-1:0] ret_data_o
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [LAT-1:0]           pv;
        logic [LAT-1:0][IW-1:0]   pidx;
        logic [LAT-1:0][DW-1:0]   pdat;
    } mm_t;

    mm_t mm_d, mm_q;

    always_comb begin
        mm_d = mm_q;
        for (int k = 1; k < LAT; k++) begin
            mm_d.pv[k]   = mm_q.pv[k-1];
            mm_d.pidx[k] = mm_q.pidx[k-1];
            mm_d.pdat[k] = mm_q.pdat[k-1];
        end
        mm_d.pv[0]   = req_valid_i && !req_write_i;
        mm_d.pidx[0] = req_idx_i;
        mm_d.pdat[0] = mm_q.mem[req_addr_i];
        if (req_valid_i && req_write_i) mm_d.mem[req_addr_i] = req_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mm_q <= '0;
        else        mm_q <= mm_d;
    end

    assign ret_valid_o = mm_q.pv[LAT-1];
    assign ret_idx_o   = mm_q.pidx[LAT-1];
    assign ret_data_o  = mm_q.pdat[LAT-1];
endmodule

// File: rtl/mem_order_unit.sv
module mem_order_unit #(
    parameter int NUM_LD  = 6,
    parameter int NUM_ST  = 3,
    parameter int AW      = 4,
    parameter int DW      = 16,
    parameter int TW      = 4,
    parameter int MEM_LAT = 2,
    localparam int IW     = $clog2(NUM_LD),
    localparam int PW     = (NUM_ST > 1) ? $clog2(NUM_ST) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid_i,
    input  logic          iss_store_i,
    input  logic [AW-1:0] iss_addr_i,
    input  logic [TW-1:0] iss_tag_i,
    input  logic [DW-1:0] iss_data_i,
    output logic          iss_ready_o,
    output logic [TW-1:0] iss_ld_tag_o,
    input  logic          rb_valid_i,
    input  logic [TW-1:0] rb_tag_i,
    input  logic [DW-1:0] rb_data_i,
    output logic          ld_done_valid_o,
    output logic [TW-1:0] ld_done_tag_o,
    output logic [DW-1:0] ld_done_data_o
);
    logic                      sq_full, sq_head_ready, push, pop, alloc;
    logic [AW-1:0]             sq_head_addr;
    logic [DW-1:0]             sq_head_data;
    logic [PW-1:0]             sq_head_idx;
    logic [NUM_ST-1:0]         sq_valid, st_done, ld_dep;
    logic [NUM_ST-1:0][AW-1:0] sq_addr;
    logic                      lt_free_any, ld_pick;
    logic [IW-1:0]             lt_free_idx, ld_gidx, ret_idx;
    logic [NUM_LD-1:0]         lt_elig, ld_grant;
    logic [NUM_LD-1:0][AW-1:0] lt_addr;
    logic                      ret_valid;
    logic [DW-1:0]             ret_data;

    assign iss_ready_o  = iss_store_i ? !sq_full : lt_free_any;
    assign push         = iss_valid_i && iss_ready_o && iss_store_i;
    assign alloc        = iss_valid_i && iss_ready_o && !iss_store_i;
    assign iss_ld_tag_o = TW'(lt_free_idx) + TW'(1);

    // loads take the memory port ahead of the head store
    always_comb begin
        ld_pick  = 1'b0;
        ld_gidx  = '0;
        ld_grant = '0;
        for (int l = NUM_LD - 1; l >= 0; l--) begin
            if (lt_elig[l]) begin
                ld_pick = 1'b1;
                ld_gidx = IW'(l);
            end
        end
        if (ld_pick) ld_grant[ld_gidx] = 1'b1;
    end

    assign pop = !ld_pick && sq_head_ready;

    always_comb begin
        st_done = '0;
        if (pop) st_done[sq_head_idx] = 1'b1;
        for (int s = 0; s < NUM_ST; s++)
            ld_dep[s] = sq_valid[s] && (sq_addr[s] == iss_addr_i) && !st_done[s];
    end

    mou_store_queue #(.NUM_ST(NUM_ST), .AW(AW), .DW(DW), .TW(TW)) u_sq (
        .clk, .rst_n,
        .push_i(push), .push_addr_i(iss_addr_i), .push_tag_i(iss_tag_i), .push_val_i(iss_data_i),
        .rb_valid_i, .rb_tag_i, .rb_data_i,
        .pop_i(pop), .full_o(sq_full), .head_ready_o(sq_head_ready),
        .head_addr_o(sq_head_addr), .head_data_o(sq_head_data), .head_idx_o(sq_head_idx),
        .valid_o(sq_valid), .addr_o(sq_addr)
    );

    mou_load_table #(.NUM_LD(NUM_LD), .NUM_ST(NUM_ST), .AW(AW)) u_lt (
        .clk, .rst_n,
        .alloc_i(alloc), .alloc_addr_i(iss_addr_i), .alloc_dep_i(ld_dep),
        .st_done_i(st_done), .grant_i(ld_grant),
        .ret_valid_i(ret_valid), .ret_idx_i(ret_idx),
        .free_any_o(lt_free_any), .free_idx_o(lt_free_idx),
        .elig_o(lt_elig), .addr_o(lt_addr)
    );

    mou_mem_model #(.AW(AW), .DW(DW), .IW(IW), .LAT(MEM_LAT)) u_mem (
        .clk, .rst_n,
        .req_valid_i(ld_pick || pop), .req_write_i(!ld_pick),
        .req_addr_i(ld_pick ? lt_addr[ld_gidx] : sq_head_addr),
        .req_wdata_i(sq_head_data), .req_idx_i(ld_gidx),
        .ret_valid_o(ret_valid), .ret_idx_o(ret_idx), .ret_data_o(ret_data)
    );

    assign ld_done_valid_o = ret_valid;
    assign ld_done_tag_o   = TW'(ret_idx) + TW'(1);
    assign ld_done_data_o  = ret_data;

    // R2: completion tags stay inside the load tag range
    p_done_tag_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done_valid_o |-> (ld_done_tag_o >= TW'(1) && ld_done_tag_o <= TW'(NUM_LD)));
    // R10: a store never takes the port while a load is eligible
    p_load_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|lt_elig) |-> !pop);
endmodule

// File: tb/mem_order_unit_bench.sv
`timescale 1ns/100ps
module mem_order_unit_bench;
    localparam int LAT = 2;
    logic clk = 0, rst_n = 0;
    logic iss_valid = 0, iss_store = 0;
    logic [3:0] iss_addr = 0, iss_tag = 0, rb_tag = 0;
    logic [15:0] iss_data = 0, rb_data = 0;
    logic rb_valid = 0;
    logic iss_ready, ld_done_valid;
    logic [3:0] iss_ld_tag, ld_done_tag;
    logic [15:0] ld_done_data;

    always #2 clk = ~clk;

    mem_order_unit #(.NUM_LD(6), .NUM_ST(3), .AW(4), .DW(16), .TW(4), .MEM_LAT(LAT)) u_mem_order_unit (
        .clk, .rst_n, .iss_valid_i(iss_valid), .iss_store_i(iss_store), .iss_addr_i(iss_addr),
        .iss_tag_i(iss_tag), .iss_data_i(iss_data), .iss_ready_o(iss_ready), .iss_ld_tag_o(iss_ld_tag),
        .rb_valid_i(rb_valid), .rb_tag_i(rb_tag), .rb_data_i(rb_data),
        .ld_done_valid_o(ld_done_valid), .ld_done_tag_o(ld_done_tag), .ld_done_data_o(ld_done_data));

    int n_chk = 0, n_bad = 0;
    logic [15:0] mdl [16];
    logic [15:0] exp_d [8];
    bit outst [8];
    logic [3:0] pq_tag [8];
    logic [15:0] pq_val [8];
    int pq_n = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // completion monitor: R2 tag validity, R8/R5 returned value
    always @(negedge clk) begin
        if (rst_n && ld_done_valid) begin
            chk(ld_done_tag >= 1 && ld_done_tag <= 6 && outst[ld_done_tag], "R2 done tag", ld_done_tag, 1);
            if (ld_done_tag >= 1 && ld_done_tag <= 6) begin
                chk(ld_done_data == exp_d[ld_done_tag], "R8 load data", ld_done_data, exp_d[ld_done_tag]);
                outst[ld_done_tag] = 0;
            end
        end
    end

    task automatic broadcast(input logic [3:0] t, input logic [15:0] v);
        rb_valid = 1; rb_tag = t; rb_data = v;
        @(negedge clk);
        rb_valid = 0;
    endtask

    task automatic service();
        if (pq_n > 0) begin
            broadcast(pq_tag[0], pq_val[0]);
            for (int i = 0; i < 7; i++) begin pq_tag[i] = pq_tag[i+1]; pq_val[i] = pq_val[i+1]; end
            pq_n--;
        end else @(negedge clk);
    endtask

    task automatic issue_load(input logic [3:0] a, output logic [3:0] t);
        iss_valid = 1; iss_store = 0; iss_addr = a;
        #0.5;
        while (!iss_ready) service();
        t = iss_ld_tag;
        chk(t >= 1 && t <= 6 && !outst[t], "R2 issue tag", t, 1);
        exp_d[t] = mdl[a];
        outst[t] = 1;
        @(negedge clk);
        iss_valid = 0;
    endtask

    task automatic issue_store(input logic [3:0] a, input logic [3:0] t, input logic [15:0] v);
        iss_valid = 1; iss_store = 1; iss_addr = a; iss_tag = t;
        iss_data = (t == 0) ? v : 16'hDEAD;
        #0.5;
        while (!iss_ready) service();
        mdl[a] = v;
        @(negedge clk);
        iss_valid = 0; iss_tag = 0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic int n_out();
        int c = 0;
        for (int i = 1; i <= 6; i++) c += outst[i];
        return c;
    endfunction

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] t, t2;
        logic [15:0] lfsr;
        int tctr;
        for (int i = 0; i < 16; i++) mdl[i] = 0;
        for (int i = 0; i < 8; i++) begin outst[i] = 0; exp_d[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        iss_store = 0; #0.5; chk(iss_ready, "R1 load ready", iss_ready, 1);
        iss_store = 1; #0.5; chk(iss_ready, "R1 store ready", iss_ready, 1);
        chk(!ld_done_valid, "R1 no done", ld_done_valid, 0);
        iss_store = 0;
        @(negedge clk);
        // R1/R9: first tag and exact latency
        issue_load(4'd5, t);
        chk(t == 1, "R1 first tag", t, 1);
        chk(!ld_done_valid, "R9 not early", ld_done_valid, 0);
        @(negedge clk);
        chk(!ld_done_valid, "R9 not early", ld_done_valid, 0);
        @(negedge clk);
        chk(ld_done_valid && ld_done_tag == 1, "R9 on time", ld_done_tag, 1);
        wait_n(3);
        // R7/R8/R5 sweep over store/load address pairs
        for (int a1 = 0; a1 < 4; a1++) begin
            for (int a2 = 0; a2 < 4; a2++) begin
                logic [15:0] v;
                v = 16'(100 + a1 * 4 + a2);
                issue_store(4'(a1), 4'd9, v);
                issue_load(4'(a2), t);
                wait_n(8);
                if (a1 != a2) chk(!outst[t], "R7 bypass", outst[t], 0);
                else          chk(outst[t], "R8 held", outst[t], 1);
                broadcast(4'd9, v);
                wait_n(8);
                chk(!outst[t], "R5 drained", outst[t], 0);
            end
        end
        // R6: values arrive reversed, order preserved
        issue_store(4'd7, 4'd10, 16'h1111);
        issue_store(4'd7, 4'd11, 16'h2222);
        issue_load(4'd7, t);
        broadcast(4'd11, 16'h2222);
        wait_n(8);
        chk(outst[t], "R6 head blocks", outst[t], 1);
        broadcast(4'd10, 16'h1111);
        wait_n(8);
        chk(!outst[t], "R6 in order", outst[t], 0);
        // R10: load between two stores wins the port
        issue_store(4'd8, 4'd12, 16'h3333);
        issue_load(4'd8, t);
        issue_store(4'd8, 4'd0, 16'h4444);
        exp_d[t] = 16'h3333;
        broadcast(4'd12, 16'h3333);
        wait_n(10);
        chk(!outst[t], "R10 done", outst[t], 0);
        issue_load(4'd8, t);
        wait_n(6);
        chk(!outst[t], "R10 newer later", outst[t], 0);
        // R3: six loads blocked, seventh stalls, store still ready
        issue_store(4'd0, 4'd13, 16'h0A0A);
        for (int i = 0; i < 6; i++) issue_load(4'd0, t2);
        chk(n_out() == 6, "R3 six out", n_out(), 6);
        iss_valid = 1; iss_store = 0; iss_addr = 4'd1; #0.5;
        chk(!iss_ready, "R3 stall", iss_ready, 0);
        iss_store = 1; #0.5;
        chk(iss_ready, "R3 store ok", iss_ready, 1);
        iss_valid = 0; iss_store = 0;
        @(negedge clk);
        broadcast(4'd13, 16'h0A0A);
        wait_n(30);
        chk(n_out() == 0, "R3 all done", n_out(), 0);
        // R4: three stores fill queue, load still bypasses
        issue_store(4'd1, 4'd14, 16'h0101);
        issue_store(4'd2, 4'd15, 16'h0202);
        issue_store(4'd3, 4'd8, 16'h0303);
        iss_valid = 1; iss_store = 1; #0.5;
        chk(!iss_ready, "R4 full", iss_ready, 0);
        iss_store = 0; #0.5;
        chk(iss_ready, "R4 load ok", iss_ready, 1);
        iss_valid = 0;
        @(negedge clk);
        issue_load(4'd5, t);
        wait_n(6);
        chk(!outst[t], "R7 past full", outst[t], 0);
        broadcast(4'd8, 16'h0303);
        broadcast(4'd15, 16'h0202);
        broadcast(4'd14, 16'h0101);
        wait_n(10);
        for (int a = 1; a <= 3; a++) issue_load(4'(a), t);
        wait_n(12);
        chk(n_out() == 0, "R9 drained", n_out(), 0);
        // mixed sequence against program-order model
        lfsr = 16'hACE1; tctr = 0;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) begin
                if (lfsr[1]) begin
                    logic [3:0] st;
                    st = 4'(8 + (tctr % 8)); tctr++;
                    issue_store(4'(lfsr[5:4]), st, lfsr ^ 16'h5A5A);
                    pq_tag[pq_n] = st; pq_val[pq_n] = lfsr ^ 16'h5A5A; pq_n++;
                end else issue_store(4'(lfsr[5:4]), 4'd0, lfsr);
            end else issue_load(4'(lfsr[7:6]), t);
            if (lfsr[8] && pq_n > 0) service();
        end
        while (pq_n > 0) service();
        wait_n(40);
        chk(n_out() == 0, "R9 all complete", n_out(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule